// File: doc/BRIEF.md
# Suspend modulation clock throttle

This block lowers the effective speed of a processor by pulsing an active-low suspend request. A prescaler turns the system clock into a fixed 32 us tick. Two 8-bit counts give the number of ticks the suspend line is held asserted (ON phase) and released (OFF phase). The block alternates between the two phases, so the processor runs at full speed times OFF/(OFF+ON).

A byte-wide write port programs the two counts, a modulation enable, per-source speedup enables and two speedup hold-off lengths. An interrupt event or a video event, when its speedup is enabled, starts a timer counted in units of about 1 ms. While either timer runs, the suspend line is forced released. When both timers have expired, modulation restarts with a fresh OFF phase. The block drives only the suspend line.

Top module: `susp_mod_throttle`

## Requirements
- R1: The tick lasts TICK_CYCLES = CLK_MHZ*TICK_US clock cycles, and every phase length is a whole number of ticks.
- R2: In steady operation `susp_no` is low for exactly ON*TICK_CYCLES cycles and then high for exactly OFF*TICK_CYCLES cycles, and this repeats.
- R3: A write is taken on a rising clock edge with `wr_en_i` high. The register addresses are: 0 = ON count, 1 = OFF count, 2 = configuration (bit 0 = modulation enable), 3 = speedup enables (bit 0 = interrupt, bit 1 = video), 4 = interrupt hold-off length, 5 = video hold-off length.
- R4: While the modulation enable is clear, `susp_no` stays high.
- R5: A phase whose count is zero is skipped. With OFF = 0 and ON > 0, `susp_no` stays low. With both counts zero, `susp_no` stays high.
- R6: New ON or OFF values do not change the phase in progress. They take effect at the next phase boundary.
- R7: An interrupt event with its speedup enabled loads a hold-off of (interrupt length * UNIT_TICKS) ticks, and `susp_no` is high while the hold-off runs. A new event during a hold-off restarts it.
- R8: A video event with its speedup enabled behaves in the same way, using the video length and its own timer.
- R9: When the last hold-off ends, modulation restarts with an OFF phase of the full OFF count.
- R10: An event whose speedup enable bit is clear has no effect on `susp_no`.
- R11: At reset all registers are zero, so `susp_no` is high and events have no effect until the block is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| irq_evt_i | input | 1 | Interrupt activity pulse |
| vid_evt_i | input | 1 | Video activity pulse |
| susp_no | output | 1 | Suspend request, active low |

## Verification
The bench builds the block with CLK_MHZ=1 and TICK_US=4, which gives a 4-cycle tick, and with UNIT_TICKS=2. At these values full ON and OFF pulses, count changes at a phase boundary, and complete speedup hold-offs with their OFF restart all fit within a few hundred cycles. Pulse widths can therefore be measured exactly against count*4 cycles. The time from an event to the next suspend assertion can be checked against a window one tick wide.

// File: rtl/smt_pkg.sv
package smt_pkg;
  localparam int CNT_W = 8;
  localparam int ADDR_W = 3;
  localparam int N_SRC = 2;
  localparam int SRC_IRQ = 0;
  localparam int SRC_VID = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_ON      = 3'd0,
    REG_OFF     = 3'd1,
    REG_CFG     = 3'd2,
    REG_SPD_EN  = 3'd3,
    REG_IRQ_LEN = 3'd4,
    REG_VID_LEN = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic [CNT_W-1:0] on_cnt;
    logic [CNT_W-1:0] off_cnt;
    logic             mod_en;
    logic [N_SRC-1:0] spd_en;
    logic [CNT_W-1:0] irq_len;
    logic [CNT_W-1:0] vid_len;
  } smt_cfg_t;
endpackage

// File: rtl/smt_regs.sv
module smt_regs
  import smt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output smt_cfg_t          cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == REG_ON)      cfg_o.on_cnt  <= wr_data_i;
      if (wr_addr_i == REG_OFF)     cfg_o.off_cnt <= wr_data_i;
      if (wr_addr_i == REG_CFG)     cfg_o.mod_en  <= wr_data_i[0];
      if (wr_addr_i == REG_SPD_EN)  cfg_o.spd_en  <= wr_data_i[N_SRC-1:0];
      if (wr_addr_i == REG_IRQ_LEN) cfg_o.irq_len <= wr_data_i;
      if (wr_addr_i == REG_VID_LEN) cfg_o.vid_len <= wr_data_i;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_o)) else $error("cfg changed without write"); // R3
endmodule

// File: rtl/smt_prescaler.sv
module smt_prescaler #(
  parameter int TICK_CYCLES = 3200
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  if (TICK_CYCLES > 1) begin : g_gap_chk
    AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o) else $error("back-to-back ticks"); // R1
  end
endmodule

// File: rtl/smt_spd_timer.sv
module smt_spd_timer #(
  parameter int CNT_W      = 8,
  parameter int UNIT_TICKS = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             hold_o
);
  localparam int RW = CNT_W + $clog2(UNIT_TICKS + 1);

  logic [RW-1:0] rem_q;
  logic [RW-1:0] load;

  assign load   = RW'(len_i) * RW'(UNIT_TICKS);
  assign hold_o = (rem_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rem_q <= '0;
    else if (evt_i)            rem_q <= load;
    else if (tick_i && hold_o) rem_q <= rem_q - 1'b1;
  end

  AST_SPD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !tick_i) |=> $stable(rem_q)) else $error("timer moved off tick"); // R7
  AST_SPD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !hold_o) |=> !hold_o) else $error("hold without event"); // R10
endmodule

// File: rtl/smt_modulator.sv
module smt_modulator #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] on_cnt_i,
  input  logic [CNT_W-1:0] off_cnt_i,
  output logic             susp_o
);
  logic             run_q;
  logic             ph_on_q;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W:0]   start_pick;
  logic [CNT_W:0]   next_pick;

  // prefer the other phase, fall back to the same one, else idle released
  function automatic logic [CNT_W:0] pick(input logic from_on,
                                          input logic [CNT_W-1:0] on_c,
                                          input logic [CNT_W-1:0] off_c);
    logic [CNT_W-1:0] oth;
    logic [CNT_W-1:0] same;
    oth  = from_on ? off_c : on_c;
    same = from_on ? on_c : off_c;
    if (oth != '0)       pick = {~from_on, oth};
    else if (same != '0) pick = {from_on, same};
    else                 pick = '0;
  endfunction

  assign start_pick = pick(1'b1, on_cnt_i, off_cnt_i);
  assign next_pick  = pick(ph_on_q, on_cnt_i, off_cnt_i);
  assign susp_o     = active_i & run_q & ph_on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; ph_on_q <= 1'b0; rem_q <= '0;
    end else if (!active_i) begin
      run_q <= 1'b0; ph_on_q <= 1'b0; rem_q <= '0;
    end else if (!run_q) begin
      run_q <= 1'b1;
      {ph_on_q, rem_q} <= start_pick;
    end else if (tick_i) begin
      if (rem_q > CNT_W'(1)) rem_q <= rem_q - 1'b1;
      else                   {ph_on_q, rem_q} <= next_pick;
    end
  end

  AST_ON_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && ph_on_q) |-> (rem_q != '0)) else $error("empty ON phase"); // R5
  AST_PH_AT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && active_i && !tick_i) |=> ($stable(ph_on_q) && $stable(rem_q)))
    else $error("phase moved between ticks"); // R6
endmodule

// File: rtl/susp_mod_throttle.sv
module susp_mod_throttle
  import smt_pkg::*;
#(
  parameter int CLK_MHZ    = 100,
  parameter int TICK_US    = 32,
  parameter int UNIT_TICKS = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              irq_evt_i,
  input  logic              vid_evt_i,
  output logic              susp_no
);
  localparam int TICK_CYCLES = CLK_MHZ * TICK_US;

  smt_cfg_t         cfg;
  logic             tick;
  logic [N_SRC-1:0] evt;
  logic [N_SRC-1:0] hold;
  logic [CNT_W-1:0] len [N_SRC];
  logic             hold_any;
  logic             active;
  logic             susp;

  assign evt[SRC_IRQ] = irq_evt_i;
  assign evt[SRC_VID] = vid_evt_i;
  assign len[SRC_IRQ] = cfg.irq_len;
  assign len[SRC_VID] = cfg.vid_len;

  smt_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .cfg_o(cfg)
  );

  smt_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_presc (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_spd
    smt_spd_timer #(.CNT_W(CNT_W), .UNIT_TICKS(UNIT_TICKS)) u_tmr (
      .clk_i, .rst_ni,
      .tick_i (tick),
      .evt_i  (evt[g] & cfg.spd_en[g]),
      .len_i  (len[g]),
      .hold_o (hold[g])
    );
  end

  assign hold_any = |hold;
  assign active   = cfg.mod_en & ~hold_any;

  smt_modulator #(.CNT_W(CNT_W)) u_mod (
    .clk_i, .rst_ni,
    .tick_i    (tick),
    .active_i  (active),
    .on_cnt_i  (cfg.on_cnt),
    .off_cnt_i (cfg.off_cnt),
    .susp_o    (susp)
  );

  assign susp_no = ~susp;

  AST_HOLD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_any |-> susp_no) else $error("suspend during speedup"); // R7
  AST_DIS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.mod_en |-> susp_no) else $error("suspend while disabled"); // R4
  AST_RESUME_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hold_any) && cfg.off_cnt != '0 && !(|(evt & cfg.spd_en)) && !wr_en_i)
      |=> susp_no) else $error("resume not in OFF"); // R9
endmodule

// File: tb/susp_mod_throttle_tb.sv
module susp_mod_throttle_tb;
  localparam int TC = 4;
  localparam int UT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       irq_evt = 1'b0;
  logic       vid_evt = 1'b0;
  logic       susp_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  susp_mod_throttle #(.CLK_MHZ(1), .TICK_US(4), .UNIT_TICKS(UT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .irq_evt_i(irq_evt), .vid_evt_i(vid_evt), .susp_no(susp_n)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input bit vid);
    @(negedge clk);
    if (vid) vid_evt = 1'b1; else irq_evt = 1'b1;
    @(negedge clk);
    vid_evt = 1'b0; irq_evt = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // cycles until suspend asserts; -1 on timeout
  task automatic wait_fall(input int max, output int n);
    logic prev;
    prev = susp_n;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (prev && !susp_n) return;
      prev = susp_n;
      if (n >= max) begin n = -1; return; end
    end
  endtask

  task automatic count_level(input logic lvl, input int max, output int n);
    n = 0;
    while (susp_n == lvl && n < max) begin
      @(negedge clk);
      n++;
    end
  endtask

  // number of samples in window where susp_n != lvl
  task automatic count_wrong(input logic lvl, input int win, output int bad);
    bad = 0;
    repeat (win) begin
      @(negedge clk);
      if (susp_n != lvl) bad++;
    end
  endtask

  function automatic int win_lo(input int len, input int off);
    return (len * UT + off - 1) * TC;
  endfunction
  function automatic int win_hi(input int len, input int off);
    return (len * UT + off) * TC + 2;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, lo, hi, bad, on_v, off_v;
    void'($urandom(32'd2024));
    idle(3);
    chk_eq("R11 reset output", int'(susp_n), 1);
    rst_n = 1'b1;
    pulse(1'b0);
    pulse(1'b1);
    count_wrong(1'b1, 40, bad);
    chk_eq("R11 idle after reset", bad, 0);

    // basic alternation
    wr(3'd0, 8'd3); wr(3'd1, 8'd2); wr(3'd2, 8'd1);
    wait_fall(200, n);
    count_level(1'b0, 400, lo); count_level(1'b1, 400, hi);
    chk_eq("R3 R2 ON width 3", lo, 3 * TC);
    chk_eq("R2 OFF width 2", hi, 2 * TC);
    count_level(1'b0, 400, lo);
    chk_eq("R2 ON width repeat", lo, 3 * TC);

    // single tick phases
    wr(3'd0, 8'd1); wr(3'd1, 8'd1);
    wait_fall(200, n);
    count_level(1'b0, 400, lo); count_level(1'b1, 400, hi);
    chk_eq("R1 one-tick ON", lo, TC);
    chk_eq("R1 one-tick OFF", hi, TC);

    // mid-phase change
    wr(3'd0, 8'd6); wr(3'd1, 8'd2);
    wait_fall(200, n);
    wait_fall(200, n);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'd1;
    lo = 0;
    while (susp_n == 1'b0 && lo < 400) begin
      @(negedge clk);
      wr_en = 1'b0;
      lo++;
    end
    count_level(1'b1, 400, hi);
    chk_eq("R6 current ON keeps old count", lo, 6 * TC);
    chk_eq("R6 OFF unchanged", hi, 2 * TC);
    count_level(1'b0, 400, lo);
    chk_eq("R6 next ON uses new count", lo, TC);

    // random counts
    for (int i = 0; i < 10; i++) begin
      on_v  = 1 + int'($urandom % 9);
      off_v = 1 + int'($urandom % 9);
      wr(3'd0, 8'(on_v)); wr(3'd1, 8'(off_v));
      wait_fall(300, n);
      wait_fall(300, n);
      count_level(1'b0, 400, lo); count_level(1'b1, 400, hi);
      chk_eq("R2 random ON", lo, on_v * TC);
      chk_eq("R2 random OFF", hi, off_v * TC);
    end

    // zero counts
    wr(3'd0, 8'd0); wr(3'd1, 8'd3);
    idle(100);
    count_wrong(1'b1, 80, bad);
    chk_eq("R5 ON=0 stays released", bad, 0);
    wr(3'd0, 8'd4); wr(3'd1, 8'd0);
    idle(100);
    count_wrong(1'b0, 80, bad);
    chk_eq("R5 OFF=0 stays asserted", bad, 0);
    wr(3'd0, 8'd0);
    idle(100);
    count_wrong(1'b1, 80, bad);
    chk_eq("R5 both zero released", bad, 0);

    // disable
    wr(3'd0, 8'd3); wr(3'd1, 8'd2);
    wait_fall(200, n);
    wr(3'd2, 8'd0);
    count_wrong(1'b1, 80, bad);
    chk_eq("R4 disabled released", bad, 0);

    // speedup
    wr(3'd2, 8'd1); wr(3'd0, 8'd2); wr(3'd1, 8'd3);
    wr(3'd4, 8'd10); wr(3'd5, 8'd5); wr(3'd3, 8'd0);
    idle(30);
    pulse(1'b0);
    wait_fall(24, n);
    chk_rng("R10 irq ignored when disabled", n, 1, 22);
    pulse(1'b1);
    wait_fall(24, n);
    chk_rng("R10 video ignored when disabled", n, 1, 22);

    wr(3'd3, 8'd3);
    idle(13);
    pulse(1'b0);
    wait_fall(300, n);
    chk_rng("R7 R9 irq hold then OFF", n, win_lo(10, 3), win_hi(10, 3));
    count_level(1'b0, 400, lo);
    chk_eq("R9 ON after resume", lo, 2 * TC);

    idle(7);
    pulse(1'b1);
    wait_fall(300, n);
    chk_rng("R8 R9 video hold then OFF", n, win_lo(5, 3), win_hi(5, 3));

    idle(5);
    pulse(1'b0);
    idle(30);
    pulse(1'b0);
    wait_fall(300, n);
    chk_rng("R7 reload restarts hold", n, win_lo(10, 3), win_hi(10, 3));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule